// File: doc/BRIEF.md
# Windowed Pixel-Array Readout Timing Generator

This block paces the readout of a rectangular window of a pixel array. It produces a frame strobe, a line strobe and a per-pixel valid strobe, together with the row and column address of every pixel it reads out, at one pixel per clock. Rows are timed as a run of active pixel clocks followed by a horizontal gap. Frames are timed as a run of active rows followed by a vertical gap of at least four rows.

The window origin and size, both gaps, the field gap and the read-mode controls come in as static inputs. The block copies them into a holding set as each frame begins, so a change made mid-frame first shows up in the next frame. The read modes are:
- reversed column order and reversed row order;
- reading every second or every fourth row;
- two interlaced modes: both fields with a programmable gap between them, or the first field only;
- three shapes of line strobe.

The sequencer has four states. `ST_VBLANK` covers the vertical gap, `ST_FIELD_A` the first (or only) field, `ST_FIELD_GAP` the rows between fields, and `ST_FIELD_B` the second field. The transitions are:
- `T_VB_LOOP`: stay in the vertical gap when the new frame has no rows.
- `T_FRAME_START`: `ST_VBLANK` to `ST_FIELD_A` after the last vertical-gap row.
- `T_A_TO_GAP`: `ST_FIELD_A` to `ST_FIELD_GAP`.
- `T_A_TO_B`: `ST_FIELD_A` to `ST_FIELD_B` when the field gap is zero.
- `T_A_TO_VB`: `ST_FIELD_A` to `ST_VBLANK` when the frame has a single field.
- `T_GAP_TO_B`: `ST_FIELD_GAP` to `ST_FIELD_B`.
- `T_B_TO_VB`: `ST_FIELD_B` to `ST_VBLANK`.

Top module: `pixel_readout_timing`

## Requirements
- R1: While `rst` is high, every output is 0. The first clock after release is pixel clock 0 of vertical-gap row 0.
- R2: A row lasts `cfg_width + cfg_hblank` clocks (at least 1). `pix_valid` is high for the first `cfg_width` clocks of each read row and low for the rest.
- R3: The vertical gap is max(`cfg_vblank`, 4) rows. A progressive frame therefore repeats every (read rows + gap rows) × row period clocks.
- R4: The row and column origins used are max(start, 4). Both addresses are 0 whenever `pix_valid` is low.
- R5: Columns run from the column origin upward, one per clock. With `cfg_col_flip`=1 they run from origin + width − 1 downward.
- R6: `cfg_row_skip` selects which rows are read: 00 reads all rows, 01 every second row (height/2 rows), 10 or 11 every fourth row (height/4 rows). With `cfg_row_flip`=1 the row offset o becomes height − 1 − o.
- R7: `cfg_interlace`=01 reads offsets 0,2,4,… ((height+1)/2 rows), then `cfg_field_blank` gap rows, then offsets 1,3,5,… (height/2 rows). `frame_valid` stays high through the field gap. Row skip is ignored in this mode.
- R8: `cfg_interlace`=10 reads only offsets 0,2,4,… (height/2 rows). Codes 00 and 11 are progressive.
- R9: `cfg_line_fmt` selects the line strobe:
  - 00 or 11: equals `pix_valid`.
  - 01: high for the first `cfg_width` clocks of every row, gap rows included.
  - 10: the 01 strobe XOR `frame_valid`.
- R10: `frame_valid` rises in the clock of the first pixel. It falls in the clock after the last pixel of the frame. `pix_valid` is never high outside `frame_valid`.
- R11: All configuration inputs are taken at the last clock of the vertical gap. A change made during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_row_start | input | ROW_W | First array row of the window |
| cfg_col_start | input | COL_W | First array column of the window |
| cfg_height | input | ROW_W | Window height in rows |
| cfg_width | input | COL_W | Window width in columns |
| cfg_hblank | input | HB_W | Horizontal gap in clocks |
| cfg_vblank | input | VB_W | Vertical gap in rows (minimum 4 applied) |
| cfg_field_blank | input | FB_W | Rows between the two interlaced fields |
| cfg_row_flip | input | 1 | Reverse row order |
| cfg_col_flip | input | 1 | Reverse column order |
| cfg_row_skip | input | 2 | Row skip select |
| cfg_interlace | input | 2 | Interlace select |
| cfg_line_fmt | input | 2 | Line strobe shape select |
| frame_valid | output | 1 | Frame strobe |
| line_valid | output | 1 | Line strobe |
| pix_valid | output | 1 | Pixel strobe |
| row_addr | output | ROW_W+1 | Row address of the current pixel |
| col_addr | output | COL_W+1 | Column address of the current pixel |

## Verification
Every output is decoded directly from the counter and state registers. A strobe or address therefore belongs to the clock in which the counters hold that position; no pipeline delay lies between them. The bench samples on falling edges and counts clocks between strobe edges:
- After reset is released, `frame_valid` is due exactly max(`cfg_vblank`, 4) × row period clocks later.
- Frame lengths are checked as the sum of in-frame and out-of-frame clock counts.

A new configuration takes effect only from the frame that starts after the next vertical-gap end. The bench therefore lets one whole frame pass after each change before it checks anything. The hold behaviour of R11 is checked by changing the width inside a running frame and counting that frame's first-row pixels.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    typedef enum logic [1:0] {
        ST_VBLANK    = 2'd0,
        ST_FIELD_A   = 2'd1,
        ST_FIELD_GAP = 2'd2,
        ST_FIELD_B   = 2'd3
    } rdo_state_e;

    localparam logic [1:0] LVF_NORMAL = 2'd0;
    localparam logic [1:0] LVF_CONT   = 2'd1;
    localparam logic [1:0] LVF_XOR    = 2'd2;

    localparam logic [1:0] ILM_PROG   = 2'd0;
    localparam logic [1:0] ILM_BOTH   = 2'd1;
    localparam logic [1:0] ILM_SINGLE = 2'd2;

    localparam int MIN_GAP_ROWS = 4;
    localparam int MIN_ORIGIN   = 4;

    function automatic logic [1:0] skip_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [15:0] first_field_rows(input logic [15:0] hgt,
                                                     input logic [1:0]  sel,
                                                     input logic [1:0]  il);
        case (il)
            ILM_BOTH:   return (hgt + 16'd1) >> 1;
            ILM_SINGLE: return hgt >> 1;
            default:    return hgt >> skip_shift(sel);
        endcase
    endfunction

    function automatic logic [15:0] second_field_rows(input logic [15:0] hgt,
                                                      input logic [1:0]  il);
        return (il == ILM_BOTH) ? (hgt >> 1) : 16'd0;
    endfunction

endpackage

// File: rtl/rdo_line_ctr.sv
module rdo_line_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] hpos,
    output logic             row_end
);

    always_comb begin
        row_end = (hpos >= period - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || row_end) begin
            hpos <= '0;
        end else begin
            hpos <= hpos + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rdo_frame_fsm.sv
module rdo_frame_fsm
    import rdo_pkg::*;
#(
    parameter int RC_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            row_end,
    input  logic [RC_W-1:0] gap_rows,
    input  logic [RC_W-1:0] rows_a,
    input  logic [RC_W-1:0] rows_b,
    input  logic [RC_W-1:0] fgap_rows,
    input  logic [RC_W-1:0] rows_a_next,
    input  logic            two_fields,
    output rdo_state_e      state,
    output logic [RC_W-1:0] rcnt,
    output logic            frame_start,
    output logic            final_row
);

    rdo_state_e      st_n;
    logic [RC_W-1:0] rc_n;
    logic            last_vb;
    logic            last_a;
    logic            last_gap;
    logic            last_b;

    always_comb begin
        last_vb  = (rcnt == gap_rows  - RC_W'(1));
        last_a   = (rcnt == rows_a    - RC_W'(1));
        last_gap = (rcnt == fgap_rows - RC_W'(1));
        last_b   = (rcnt == rows_b    - RC_W'(1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_VBLANK;
            rcnt  <= '0;
        end else begin
            state <= st_n;
            rcnt  <= rc_n;
        end
    end

    // next state
    always_comb begin
        st_n = state;
        rc_n = rcnt;
        if (row_end) begin
            rc_n = rcnt + RC_W'(1);
            unique case (state)
                ST_VBLANK: begin
                    if (last_vb) begin
                        rc_n = '0;
                        // T_FRAME_START or T_VB_LOOP
                        st_n = (rows_a_next != '0) ? ST_FIELD_A : ST_VBLANK;
                    end
                end
                ST_FIELD_A: begin
                    if (last_a) begin
                        rc_n = '0;
                        if (!two_fields) begin
                            st_n = ST_VBLANK;        // T_A_TO_VB
                        end else if (fgap_rows != '0) begin
                            st_n = ST_FIELD_GAP;     // T_A_TO_GAP
                        end else begin
                            st_n = ST_FIELD_B;       // T_A_TO_B
                        end
                    end
                end
                ST_FIELD_GAP: begin
                    if (last_gap) begin
                        rc_n = '0;
                        st_n = ST_FIELD_B;           // T_GAP_TO_B
                    end
                end
                ST_FIELD_B: begin
                    if (last_b) begin
                        rc_n = '0;
                        st_n = ST_VBLANK;            // T_B_TO_VB
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        frame_start = row_end && (state == ST_VBLANK) && last_vb;
        final_row   = ((state == ST_FIELD_A) && last_a && !two_fields) ||
                      ((state == ST_FIELD_B) && last_b);
    end

endmodule

// File: rtl/rdo_addr_gen.sv
module rdo_addr_gen
    import rdo_pkg::*;
#(
    parameter int ROW_W = 9,
    parameter int COL_W = 10,
    parameter int RC_W  = 10,
    parameter int H_W   = 11,
    parameter int RA_W  = ROW_W + 1,
    parameter int CA_W  = COL_W + 1
) (
    input  logic             pix,
    input  rdo_state_e       state,
    input  logic [RC_W-1:0]  rcnt,
    input  logic [H_W-1:0]   hpos,
    input  logic [ROW_W-1:0] origin_row,
    input  logic [COL_W-1:0] origin_col,
    input  logic [ROW_W-1:0] height,
    input  logic [COL_W-1:0] width,
    input  logic             row_flip,
    input  logic             col_flip,
    input  logic [1:0]       skip_sh,
    input  logic             interlaced,
    output logic [RA_W-1:0]  row_addr,
    output logic [CA_W-1:0]  col_addr
);

    logic [RA_W-1:0] roff;
    logic [RA_W-1:0] rrel;
    logic [CA_W-1:0] hc;
    logic [CA_W-1:0] crel;

    always_comb begin
        if (state == ST_FIELD_B) begin
            roff = (RA_W'(rcnt) << 1) + RA_W'(1);
        end else if (interlaced) begin
            roff = RA_W'(rcnt) << 1;
        end else begin
            roff = RA_W'(rcnt) << skip_sh;
        end
        rrel = row_flip ? (RA_W'(height) - RA_W'(1) - roff) : roff;
        hc   = CA_W'(hpos);
        crel = col_flip ? (CA_W'(width) - CA_W'(1) - hc) : hc;
        row_addr = pix ? (RA_W'(origin_row) + rrel) : '0;
        col_addr = pix ? (CA_W'(origin_col) + crel) : '0;
    end

endmodule

// File: rtl/pixel_readout_timing.sv
module pixel_readout_timing
    import rdo_pkg::*;
#(
    parameter int ROW_W = 9,
    parameter int COL_W = 10,
    parameter int HB_W  = 10,
    parameter int VB_W  = 10,
    parameter int FB_W  = 8,
    localparam int RA_W = ROW_W + 1,
    localparam int CA_W = COL_W + 1,
    localparam int H_W  = ((COL_W > HB_W) ? COL_W : HB_W) + 1,
    localparam int RC_A = (ROW_W > VB_W) ? ROW_W : VB_W,
    localparam int RC_W = ((RC_A > FB_W) ? RC_A : FB_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] cfg_row_start,
    input  logic [COL_W-1:0] cfg_col_start,
    input  logic [ROW_W-1:0] cfg_height,
    input  logic [COL_W-1:0] cfg_width,
    input  logic [HB_W-1:0]  cfg_hblank,
    input  logic [VB_W-1:0]  cfg_vblank,
    input  logic [FB_W-1:0]  cfg_field_blank,
    input  logic             cfg_row_flip,
    input  logic             cfg_col_flip,
    input  logic [1:0]       cfg_row_skip,
    input  logic [1:0]       cfg_interlace,
    input  logic [1:0]       cfg_line_fmt,
    output logic             frame_valid,
    output logic             line_valid,
    output logic             pix_valid,
    output logic [RA_W-1:0]  row_addr,
    output logic [CA_W-1:0]  col_addr
);

    // held configuration
    logic [ROW_W-1:0] row_start_q;
    logic [COL_W-1:0] col_start_q;
    logic [ROW_W-1:0] height_q;
    logic [COL_W-1:0] width_q;
    logic [HB_W-1:0]  hblank_q;
    logic [VB_W-1:0]  vblank_q;
    logic [FB_W-1:0]  fblank_q;
    logic             row_flip_q;
    logic             col_flip_q;
    logic [1:0]       skip_q;
    logic [1:0]       ilace_q;
    logic [1:0]       fmt_q;

    // derived values
    logic [ROW_W-1:0] origin_row;
    logic [COL_W-1:0] origin_col;
    logic [RC_W-1:0]  gap_rows;
    logic [RC_W-1:0]  rows_a;
    logic [RC_W-1:0]  rows_b;
    logic [RC_W-1:0]  fgap_rows;
    logic [RC_W-1:0]  rows_a_next;
    logic             two_fields;
    logic             interlaced;
    logic [H_W-1:0]   period_raw;
    logic [H_W-1:0]   period;

    // sequencer
    logic [H_W-1:0]   hpos;
    logic             row_end;
    rdo_state_e       state;
    logic [RC_W-1:0]  rcnt;
    logic             frame_start;
    logic             final_row;

    // output terms
    logic             in_width;
    logic             pix_i;
    logic             fv_i;
    logic             lv_i;
    logic [RA_W-1:0]  row_addr_i;
    logic [CA_W-1:0]  col_addr_i;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            row_start_q <= cfg_row_start;
            col_start_q <= cfg_col_start;
            height_q    <= cfg_height;
            width_q     <= cfg_width;
            hblank_q    <= cfg_hblank;
            vblank_q    <= cfg_vblank;
            fblank_q    <= cfg_field_blank;
            row_flip_q  <= cfg_row_flip;
            col_flip_q  <= cfg_col_flip;
            skip_q      <= cfg_row_skip;
            ilace_q     <= cfg_interlace;
            fmt_q       <= cfg_line_fmt;
        end
    end

    always_comb begin
        origin_row  = (row_start_q < ROW_W'(MIN_ORIGIN)) ? ROW_W'(MIN_ORIGIN) : row_start_q;
        origin_col  = (col_start_q < COL_W'(MIN_ORIGIN)) ? COL_W'(MIN_ORIGIN) : col_start_q;
        gap_rows    = (vblank_q < VB_W'(MIN_GAP_ROWS)) ? RC_W'(MIN_GAP_ROWS) : RC_W'(vblank_q);
        rows_a      = RC_W'(first_field_rows(16'(height_q), skip_q, ilace_q));
        rows_b      = RC_W'(second_field_rows(16'(height_q), ilace_q));
        rows_a_next = RC_W'(first_field_rows(16'(cfg_height), cfg_row_skip, cfg_interlace));
        fgap_rows   = RC_W'(fblank_q);
        two_fields  = (ilace_q == ILM_BOTH) && (rows_b != '0);
        interlaced  = (ilace_q == ILM_BOTH) || (ilace_q == ILM_SINGLE);
        period_raw  = H_W'(width_q) + H_W'(hblank_q);
        period      = (period_raw == '0) ? H_W'(1) : period_raw;
    end

    rdo_line_ctr #(
        .CNT_W (H_W)
    ) line_ctr_i (
        .clk     (clk),
        .rst     (rst),
        .period  (period),
        .hpos    (hpos),
        .row_end (row_end)
    );

    rdo_frame_fsm #(
        .RC_W (RC_W)
    ) frame_fsm_i (
        .clk         (clk),
        .rst         (rst),
        .row_end     (row_end),
        .gap_rows    (gap_rows),
        .rows_a      (rows_a),
        .rows_b      (rows_b),
        .fgap_rows   (fgap_rows),
        .rows_a_next (rows_a_next),
        .two_fields  (two_fields),
        .state       (state),
        .rcnt        (rcnt),
        .frame_start (frame_start),
        .final_row   (final_row)
    );

    always_comb begin
        in_width = (hpos < H_W'(width_q));
        pix_i    = !rst && ((state == ST_FIELD_A) || (state == ST_FIELD_B)) && in_width;
        fv_i     = (state != ST_VBLANK) && !(final_row && !in_width);
        unique case (fmt_q)
            LVF_CONT: lv_i = in_width;
            LVF_XOR:  lv_i = in_width ^ fv_i;
            default:  lv_i = pix_i;
        endcase
    end

    rdo_addr_gen #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .RC_W  (RC_W),
        .H_W   (H_W),
        .RA_W  (RA_W),
        .CA_W  (CA_W)
    ) addr_gen_i (
        .pix        (pix_i),
        .state      (state),
        .rcnt       (rcnt),
        .hpos       (hpos),
        .origin_row (origin_row),
        .origin_col (origin_col),
        .height     (height_q),
        .width      (width_q),
        .row_flip   (row_flip_q),
        .col_flip   (col_flip_q),
        .skip_sh    (skip_shift(skip_q)),
        .interlaced (interlaced),
        .row_addr   (row_addr_i),
        .col_addr   (col_addr_i)
    );

    always_comb begin
        pix_valid   = pix_i;
        frame_valid = !rst && fv_i;
        line_valid  = !rst && lv_i;
        row_addr    = row_addr_i;
        col_addr    = col_addr_i;
    end

endmodule

// File: rtl/pixel_readout_timing_chk.sv
module pixel_readout_timing_chk #(
    parameter int RA_W = 10,
    parameter int CA_W = 11
) (
    input logic            clk,
    input logic            rst,
    input logic            frame_valid,
    input logic            pix_valid,
    input logic [RA_W-1:0] row_addr,
    input logic [CA_W-1:0] col_addr,
    input logic            col_flip_q
);

    logic [7:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || frame_valid) begin
            low_run <= '0;
        end else if (low_run != 8'hFF) begin
            low_run <= low_run + 8'd1;
        end
    end

    AST_PIX_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> frame_valid); // R10

    AST_FRAME_OPENS_ON_PIXEL: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_valid) |-> pix_valid); // R10

    AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> (row_addr == '0 && col_addr == '0)); // R4

    AST_ORIGIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (row_addr >= RA_W'(4) && col_addr >= CA_W'(4))); // R4

    AST_COL_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid) && row_addr == $past(row_addr) && !col_flip_q)
        |-> col_addr == $past(col_addr) + 1'b1); // R5

    AST_COL_DESCEND: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid) && row_addr == $past(row_addr) && col_flip_q)
        |-> col_addr == $past(col_addr) - 1'b1); // R5

    AST_GAP_MIN_ROWS: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_valid) |-> low_run >= 8'd4); // R3

endmodule

bind pixel_readout_timing pixel_readout_timing_chk #(
    .RA_W (RA_W),
    .CA_W (CA_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .pix_valid   (pix_valid),
    .row_addr    (row_addr),
    .col_addr    (col_addr),
    .col_flip_q  (col_flip_q)
);

// File: tb/pixel_readout_timing_tb_top.sv
module pixel_readout_timing_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  cfg_row_start;
    logic [9:0]  cfg_col_start;
    logic [8:0]  cfg_height;
    logic [9:0]  cfg_width;
    logic [9:0]  cfg_hblank;
    logic [9:0]  cfg_vblank;
    logic [7:0]  cfg_field_blank;
    logic        cfg_row_flip;
    logic        cfg_col_flip;
    logic [1:0]  cfg_row_skip;
    logic [1:0]  cfg_interlace;
    logic [1:0]  cfg_line_fmt;
    logic        frame_valid;
    logic        line_valid;
    logic        pix_valid;
    logic [9:0]  row_addr;
    logic [10:0] col_addr;

    int n_tests = 0;
    int n_fail  = 0;

    int rows_seen [0:63];
    int nrows, first_npix, col_first, col_last;
    int in_cyc, out_cyc, lv_in, lv_out, pix_total;
    int rise_pix, fall_prev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pixel_readout_timing dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_row_start   (cfg_row_start),
        .cfg_col_start   (cfg_col_start),
        .cfg_height      (cfg_height),
        .cfg_width       (cfg_width),
        .cfg_hblank      (cfg_hblank),
        .cfg_vblank      (cfg_vblank),
        .cfg_field_blank (cfg_field_blank),
        .cfg_row_flip    (cfg_row_flip),
        .cfg_col_flip    (cfg_col_flip),
        .cfg_row_skip    (cfg_row_skip),
        .cfg_interlace   (cfg_interlace),
        .cfg_line_fmt    (cfg_line_fmt),
        .frame_valid     (frame_valid),
        .line_valid      (line_valid),
        .pix_valid       (pix_valid),
        .row_addr        (row_addr),
        .col_addr        (col_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int rs, input int cs, input int h, input int w,
                           input int hb, input int vb, input int fb,
                           input int rf, input int cf, input int sk,
                           input int il, input int fmt);
        @(negedge clk);
        cfg_row_start   = 9'(rs);
        cfg_col_start   = 10'(cs);
        cfg_height      = 9'(h);
        cfg_width       = 10'(w);
        cfg_hblank      = 10'(hb);
        cfg_vblank      = 10'(vb);
        cfg_field_blank = 8'(fb);
        cfg_row_flip    = 1'(rf);
        cfg_col_flip    = 1'(cf);
        cfg_row_skip    = 2'(sk);
        cfg_interlace   = 2'(il);
        cfg_line_fmt    = 2'(fmt);
    endtask

    // measures one frame from frame_valid rise to the next rise
    task automatic capture();
        int prev_pix;
        int prev_row;
        nrows = 0; first_npix = 0; col_first = -1; col_last = -1;
        in_cyc = 0; out_cyc = 0; lv_in = 0; lv_out = 0; pix_total = 0;
        prev_pix = 0; prev_row = -1;
        @(negedge clk);
        while (frame_valid) @(negedge clk);
        while (!frame_valid) @(negedge clk);
        rise_pix = int'(pix_valid);
        while (frame_valid) begin
            in_cyc++;
            if (line_valid) lv_in++;
            if (pix_valid) begin
                pix_total++;
                if ((prev_pix == 0 || int'(row_addr) != prev_row) && nrows < 64) begin
                    rows_seen[nrows] = int'(row_addr);
                    nrows++;
                end
                if (nrows == 1) begin
                    first_npix++;
                    if (col_first < 0) col_first = int'(col_addr);
                    col_last = int'(col_addr);
                end
                prev_row = int'(row_addr);
            end
            prev_pix = int'(pix_valid);
            @(negedge clk);
        end
        fall_prev = prev_pix;
        while (!frame_valid) begin
            out_cyc++;
            if (line_valid) lv_out++;
            @(negedge clk);
        end
    endtask

    task automatic settle();
        capture();
        capture();
    endtask

    task automatic check_rows(input string tag, input int idx0, input int first,
                              input int step, input int count);
        for (int i = 0; i < count; i++) begin
            chk(tag, rows_seen[idx0 + i], first + i * step);
        end
    endtask

    task automatic t_reset();
        int n;
        set_cfg(10, 20, 6, 8, 4, 2, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 outputs low in reset",
            int'(frame_valid | line_valid | pix_valid | (row_addr != 0) | (col_addr != 0)), 0);
        rst = 1'b0;
        n = 0;
        @(negedge clk);
        n++;
        while (!frame_valid) begin
            @(negedge clk);
            n++;
        end
        chk("R1 R3 first frame after release", n, 48);
    endtask

    task automatic t_progressive();
        set_cfg(10, 20, 6, 8, 4, 5, 0, 0, 0, 0, 0, 0);
        settle();
        chk("R6 progressive row count", nrows, 6);
        check_rows("R6 progressive rows", 0, 10, 1, 6);
        chk("R2 pixels per row", first_npix, 8);
        chk("R5 first column", col_first, 20);
        chk("R5 last column", col_last, 27);
        chk("R2 pixel total", pix_total, 48);
        chk("R10 frame span", in_cyc, 68);
        chk("R3 frame period", in_cyc + out_cyc, 132);
        chk("R10 pixel at frame rise", rise_pix, 1);
        chk("R10 pixel before frame fall", fall_prev, 1);
        chk("R9 normal strobe in frame", lv_in, 48);
        chk("R9 normal strobe outside", lv_out, 0);
    endtask

    task automatic t_no_hblank();
        set_cfg(10, 20, 2, 8, 0, 4, 0, 0, 0, 0, 0, 0);
        settle();
        chk("R2 zero hblank rows", nrows, 2);
        chk("R2 zero hblank pixels", pix_total, 16);
        chk("R3 zero hblank period", in_cyc + out_cyc, 48);
    endtask

    task automatic t_clamp();
        set_cfg(1, 0, 3, 8, 4, 0, 0, 0, 0, 0, 0, 0);
        settle();
        check_rows("R4 row origin floor", 0, 4, 1, 3);
        chk("R4 column origin floor", col_first, 4);
        chk("R3 vblank floor period", in_cyc + out_cyc, 84);
    endtask

    task automatic t_flip();
        set_cfg(10, 20, 6, 8, 4, 5, 0, 1, 1, 0, 0, 0);
        settle();
        check_rows("R6 row flip", 0, 15, -1, 6);
        chk("R5 flipped first column", col_first, 27);
        chk("R5 flipped last column", col_last, 20);
    endtask

    task automatic t_skip();
        set_cfg(10, 20, 8, 8, 4, 5, 0, 0, 0, 1, 0, 0);
        settle();
        chk("R6 half skip count", nrows, 4);
        check_rows("R6 half skip rows", 0, 10, 2, 4);
        chk("R6 half skip period", in_cyc + out_cyc, 108);
        set_cfg(10, 20, 8, 8, 4, 5, 0, 0, 0, 2, 0, 0);
        settle();
        chk("R6 quarter skip count", nrows, 2);
        check_rows("R6 quarter skip rows", 0, 10, 4, 2);
        set_cfg(10, 20, 8, 8, 4, 5, 0, 0, 0, 3, 0, 0);
        settle();
        chk("R6 skip code 11 count", nrows, 2);
        check_rows("R6 skip code 11 rows", 0, 10, 4, 2);
        set_cfg(10, 20, 8, 8, 4, 5, 0, 1, 0, 1, 0, 0);
        settle();
        check_rows("R6 half skip flipped", 0, 17, -2, 4);
    endtask

    task automatic t_interlace();
        set_cfg(10, 20, 6, 8, 4, 5, 2, 0, 0, 0, 1, 0);
        settle();
        chk("R7 two-field row count", nrows, 6);
        check_rows("R7 even field", 0, 10, 2, 3);
        check_rows("R7 odd field", 3, 11, 2, 3);
        chk("R7 frame held through field gap", in_cyc, 92);
        chk("R7 two-field period", in_cyc + out_cyc, 156);
        set_cfg(10, 20, 6, 8, 4, 5, 2, 0, 0, 0, 2, 0);
        settle();
        chk("R8 single-field count", nrows, 3);
        check_rows("R8 single-field rows", 0, 10, 2, 3);
        chk("R8 single-field period", in_cyc + out_cyc, 96);
        set_cfg(10, 20, 6, 8, 4, 5, 2, 0, 0, 0, 3, 0);
        settle();
        chk("R8 code 11 progressive", nrows, 6);
    endtask

    task automatic t_line_fmt();
        set_cfg(10, 20, 6, 8, 4, 5, 0, 0, 0, 0, 0, 1);
        settle();
        chk("R9 continuous in frame", lv_in, 48);
        chk("R9 continuous outside", lv_out, 40);
        set_cfg(10, 20, 6, 8, 4, 5, 0, 0, 0, 0, 0, 2);
        settle();
        chk("R9 xor in frame", lv_in, 20);
        chk("R9 xor outside", lv_out, 40);
        set_cfg(10, 20, 6, 8, 4, 5, 0, 0, 0, 0, 0, 3);
        settle();
        chk("R9 code 11 in frame", lv_in, 48);
        chk("R9 code 11 outside", lv_out, 0);
    endtask

    task automatic t_hold();
        int cnt;
        set_cfg(10, 20, 6, 8, 4, 5, 0, 0, 0, 0, 0, 0);
        settle();
        @(negedge clk);
        while (frame_valid) @(negedge clk);
        while (!frame_valid) @(negedge clk);
        cnt = int'(pix_valid);
        cfg_width = 10'd5;
        @(negedge clk);
        while (pix_valid) begin
            cnt++;
            @(negedge clk);
        end
        chk("R11 running frame keeps width", cnt, 8);
        capture();
        chk("R11 next frame uses new width", first_npix, 5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_progressive();
        t_no_hblank();
        t_clamp();
        t_flip();
        t_skip();
        t_interlace();
        t_line_fmt();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule